// File: doc/BRIEF.md
# Toggle-Bit Polling Controller

This block runs on the host side of a parallel flash bus once a program or erase command has been written to the device. It samples the device's status byte through a simple read request/acknowledge port. Completion is found by comparing a status bit across two reads in a row, not by waiting for a ready flag. When the toggle bit keeps changing, the controller looks at the device's time-limit bit. If that bit is high, the controller makes one last confirming read pair. This covers the race where toggling stops on the same read in which the time-limit bit rises. A programmable limit on the number of ordinary read pairs bounds the wait.

A second mode, query, performs a single read pair at a chosen sector address and reports three things: whether an erase is running, whether the sector sits in erase suspend, and whether the sector is among those selected for erase. Commands, data verification and the device itself lie outside the block.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: After reset, busy, done, fail, rd_req and all three status outputs are low.
- R2: A start accepted in idle latches sector_addr onto rd_addr and issues exactly two reads per pair. rd_req stays high until rd_ack, and each rd_ack cycle delivers one byte on rd_data.
- R3: In poll mode, if bit 6 of the two bytes of a pair is equal, done is high for one cycle, in the second cycle after the cycle holding the pair's final rd_ack.
- R4: If bit 6 differs and bit 5 of the pair's second byte is low, another pair follows. When MAX_POLLS such pairs have all toggled, fail is raised instead of a new pair.
- R5: If bit 6 differs and bit 5 of the second byte is high, exactly one confirming pair follows, and it does not count toward MAX_POLLS. If bit 6 is stable in that pair the result is done; if it still differs the result is fail.
- R6: done and fail are one-cycle pulses that never occur together. While either pulse is high, busy is low and the controller is idle.
- R7: A start seen while busy is ignored. rd_addr, the mode, the number of reads and the outcome are unchanged.
- R8: In query mode (query high with start), one pair is read and done follows. The status outputs are then set as follows: st_erasing is 1 when bit 6 differs; st_sector_sel is 1 when bit 2 differs; st_suspended is 1 when bit 6 is equal and bit 2 differs. They hold until the next query concludes, so a poll leaves them unchanged.
- R9: busy is high from the cycle after an accepted start until the cycle in which done or fail pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll or a query (used only when idle) |
| query | input | 1 | With start: 1 selects query mode, 0 selects poll mode |
| sector_addr | input | ADDR_W | Address read during the operation |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Address of the requested read |
| rd_ack | input | 1 | Read acknowledge, one cycle per byte |
| rd_data | input | DATA_W | Byte returned with rd_ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse (limit or confirmed toggling) |
| st_erasing | output | 1 | Last query saw bit 6 toggling |
| st_suspended | output | 1 | Last query saw bit 6 stable and bit 2 toggling |
| st_sector_sel | output | 1 | Last query saw bit 2 toggling |

## Verification
The bench builds the block with MAX_POLLS=5 and ADDR_W=12, and keeps the status path enabled. The small limit puts pair-count exhaustion within a few dozen cycles, so the bench can hit the last-pair boundary from both sides: nine toggling reads end in done and eleven end in fail. The responder adds a random latency of zero to three cycles per read, which stretches the request/acknowledge timing. The bit-5 race, where toggling stops just as bit 5 rises, is reached both by directed cases and by random values of the toggle-stop and bit-5 read indices.

// File: rtl/tbp_pkg.sv
`timescale 1ns/1ps
package tbp_pkg;

   typedef enum logic [1:0] {
      RD_IDLE   = 2'd0,
      RD_FIRST  = 2'd1,
      RD_SECOND = 2'd2
   } rd_state_t;

   typedef enum logic {
      CT_IDLE = 1'b0,
      CT_WAIT = 1'b1
   } ctl_state_t;

   function automatic int cnt_width(input int limit);
      return (limit > 1) ? $clog2(limit) : 1;
   endfunction

endpackage

// File: rtl/tbp_pair_reader.sv
`timescale 1ns/1ps
module tbp_pair_reader
   import tbp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              rd_req,
   output logic              pair_valid,
   output logic [DATA_W-1:0] first_q,
   output logic [DATA_W-1:0] second_q
);

   rd_state_t st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= RD_IDLE;
         pair_valid <= 1'b0;
         first_q    <= '0;
         second_q   <= '0;
      end else begin
         pair_valid <= 1'b0;
         unique case (st_q)
            RD_IDLE: if (go) st_q <= RD_FIRST;
            RD_FIRST: if (rd_ack) begin
               first_q <= rd_data;
               st_q    <= RD_SECOND;
            end
            RD_SECOND: if (rd_ack) begin
               second_q   <= rd_data;
               pair_valid <= 1'b1;
               st_q       <= RD_IDLE;
            end
            default: st_q <= RD_IDLE;
         endcase
      end
   end

   assign rd_req = (st_q != RD_IDLE);

   // R2: request is held until acknowledged
   assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ack |=> rd_req);

   // R2: the controller launches a pair only when the reader is free
   assert_go_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !rd_req);

   // R2: a completed pair is reported one cycle after its second acknowledge
   assert_pair_after_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |-> !rd_req);

endmodule

// File: rtl/tbp_limit_counter.sv
`timescale 1ns/1ps
module tbp_limit_counter
   import tbp_pkg::*;
#(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_last
);

   localparam int CNT_W = cnt_width(LIMIT);

   generate
      if (LIMIT == 1) begin : g_single
         logic unused_lc;
         assign unused_lc = ^{clk, rst_n, clr, inc};
         assign at_last   = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)             cnt_q <= '0;
            else if (clr)           cnt_q <= '0;
            else if (inc && !at_last) cnt_q <= cnt_q + 1'b1;
         end

         assign at_last = (cnt_q == CNT_W'(LIMIT - 1));

         // R4: the pair count never passes the programmed limit
         assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= CNT_W'(LIMIT - 1));
      end
   endgenerate

endmodule

// File: rtl/tbp_status_unit.sv
`timescale 1ns/1ps
module tbp_status_unit #(
   parameter int DATA_W  = 8,
   parameter int ACT_BIT = 6,
   parameter int SEL_BIT = 2,
   parameter bit ENABLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] first_b,
   input  logic [DATA_W-1:0] second_b,
   output logic              st_erasing,
   output logic              st_suspended,
   output logic              st_sector_sel
);

   generate
      if (ENABLE) begin : g_status
         logic act_moved, sel_moved;
         logic unused_su;
         assign act_moved = first_b[ACT_BIT] ^ second_b[ACT_BIT];
         assign sel_moved = first_b[SEL_BIT] ^ second_b[SEL_BIT];
         assign unused_su = ^{first_b, second_b};

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               st_erasing    <= 1'b0;
               st_suspended  <= 1'b0;
               st_sector_sel <= 1'b0;
            end else if (capture) begin
               st_erasing    <= act_moved;
               st_suspended  <= !act_moved && sel_moved;
               st_sector_sel <= sel_moved;
            end
         end

         // R8: status only changes on the cycle after a capture
         assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !capture |=> $stable({st_erasing, st_suspended, st_sector_sel}));
      end else begin : g_nostatus
         logic unused_su;
         assign unused_su     = ^{clk, rst_n, capture, first_b, second_b};
         assign st_erasing    = 1'b0;
         assign st_suspended  = 1'b0;
         assign st_sector_sel = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/tbp_poll_ctrl.sv
`timescale 1ns/1ps
module tbp_poll_ctrl
   import tbp_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 8,
   parameter int ACT_BIT   = 6,
   parameter int LIM_BIT   = 5,
   parameter int SEL_BIT   = 2,
   parameter int MAX_POLLS = 64,
   parameter bit STATUS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              query,
   input  logic [ADDR_W-1:0] sector_addr,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              st_erasing,
   output logic              st_suspended,
   output logic              st_sector_sel
);

   initial begin
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
      assert (DATA_W >= 3) else $error("DATA_W too small for the status bits");
      assert (MAX_POLLS >= 1) else $error("MAX_POLLS must be at least 1");
      assert (ACT_BIT < DATA_W && LIM_BIT < DATA_W && SEL_BIT < DATA_W)
         else $error("status bit index outside the data width");
      assert (ACT_BIT != LIM_BIT && ACT_BIT != SEL_BIT && LIM_BIT != SEL_BIT)
         else $error("status bit indices must be distinct");
   end

   ctl_state_t        state_q;
   logic              mode_q;
   logic              recheck_q;
   logic [ADDR_W-1:0] addr_q;
   logic              done_q, fail_q;

   logic              go, pair_valid;
   logic [DATA_W-1:0] first_q, second_q;
   logic              act_moved, lim_high;
   logic              finish_ok, finish_bad, cnt_inc, set_recheck, at_last;
   logic              accept;
   logic              unused_top;

   tbp_pair_reader #(.DATA_W(DATA_W)) u_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .rd_ack     (rd_ack),
      .rd_data    (rd_data),
      .rd_req     (rd_req),
      .pair_valid (pair_valid),
      .first_q    (first_q),
      .second_q   (second_q)
   );

   tbp_limit_counter #(.LIMIT(MAX_POLLS)) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .inc     (cnt_inc),
      .at_last (at_last)
   );

   tbp_status_unit #(
      .DATA_W  (DATA_W),
      .ACT_BIT (ACT_BIT),
      .SEL_BIT (SEL_BIT),
      .ENABLE  (STATUS_EN)
   ) u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .capture       (pair_valid && state_q == CT_WAIT && mode_q),
      .first_b       (first_q),
      .second_b      (second_q),
      .st_erasing    (st_erasing),
      .st_suspended  (st_suspended),
      .st_sector_sel (st_sector_sel)
   );

   assign act_moved  = first_q[ACT_BIT] ^ second_q[ACT_BIT];
   assign lim_high   = second_q[LIM_BIT];
   assign accept     = (state_q == CT_IDLE) && start;
   assign unused_top = ^{first_q, second_q};

   always_comb begin
      go          = accept;
      finish_ok   = 1'b0;
      finish_bad  = 1'b0;
      cnt_inc     = 1'b0;
      set_recheck = 1'b0;
      if (state_q == CT_WAIT && pair_valid) begin
         if (mode_q || !act_moved) begin
            finish_ok = 1'b1;
         end else if (recheck_q) begin
            finish_bad = 1'b1;
         end else if (lim_high) begin
            set_recheck = 1'b1;
            go          = 1'b1;
         end else begin
            cnt_inc = 1'b1;
            if (at_last) finish_bad = 1'b1;
            else         go         = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= CT_IDLE;
         mode_q    <= 1'b0;
         recheck_q <= 1'b0;
         addr_q    <= '0;
         done_q    <= 1'b0;
         fail_q    <= 1'b0;
      end else begin
         done_q <= finish_ok;
         fail_q <= finish_bad;
         if (accept) begin
            state_q   <= CT_WAIT;
            addr_q    <= sector_addr;
            mode_q    <= query;
            recheck_q <= 1'b0;
         end else if (finish_ok || finish_bad) begin
            state_q <= CT_IDLE;
         end
         if (set_recheck) recheck_q <= 1'b1;
      end
   end

   assign busy    = (state_q == CT_WAIT);
   assign done    = done_q;
   assign fail    = fail_q;
   assign rd_addr = addr_q;

   // R6: results are single-cycle pulses
   assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |=> !(done || fail));

   // R6: a result is never reported while busy
   assert_idle_on_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> !busy && !rd_req);

   // R7: a start during a running operation leaves the address alone
   assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(rd_addr));

   // R9: busy only rises after a start request
   assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R5: the confirming pair is entered only on a high limit bit
   assert_recheck_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recheck_q) |-> $past(lim_high && pair_valid));

endmodule

// File: tb/tb_tbp_poll_ctrl.sv
`timescale 1ns/1ps
module tb_tbp_poll_ctrl;

   localparam int AW  = 12;
   localparam int DW  = 8;
   localparam int MAXP = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          query = 1'b0;
   logic [AW-1:0] sector_addr = '0;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic          rd_ack = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic          busy, done, fail;
   logic          st_erasing, st_suspended, st_sector_sel;

   tbp_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .query(query),
      .sector_addr(sector_addr), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done),
      .fail(fail), .st_erasing(st_erasing), .st_suspended(st_suspended),
      .st_sector_sel(st_sector_sel)
   );

   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // flash behaviour: toggle stops after read n, bit 5 high from read d
   bit  model_q = 0;
   int  mn = 0, md = 99;
   bit  q6 = 0, q2 = 0;
   int  tot = 0, base = 0;
   int  wcnt = 0, lat = 0;

   function automatic logic [DW-1:0] make_byte(input int k);
      logic [DW-1:0] b;
      b = DW'($urandom);
      if (!model_q) begin
         if (k < mn)      b[6] = k[0];
         else if (mn > 0) b[6] = 1'(mn - 1);
         else             b[6] = 1'b0;
         b[5] = (k >= md);
      end else begin
         b[6] = q6 ? k[0] : 1'b1;
         b[2] = q2 ? ~k[0] : 1'b0;
      end
      return b;
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 1;
      rd_ack <= 1'b0;
      if (!rst_n) begin
         wcnt <= 0;
      end else if (rd_req && !rd_ack) begin
         if (wcnt >= lat) begin
            rd_ack  <= 1'b1;
            rd_data <= make_byte(tot - base);
            tot     <= tot + 1;
            wcnt    <= 0;
            lat     <= int'($urandom_range(0, 3));
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   // monitor, sampled at the falling edge
   int last_ack = 0, done_cyc = 0, fail_cyc = 0, done_seen = 0, fail_seen = 0;
   logic [AW-1:0] exp_addr = '0;
   bit addr_bad = 0;
   always @(negedge clk) begin
      if (rd_ack) begin
         last_ack = cyc;
         if (rd_addr != exp_addr) addr_bad = 1;
      end
      if (done) begin done_seen++; done_cyc = cyc; end
      if (fail) begin fail_seen++; fail_cyc = cyc; end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #0.5;
   endtask

   // outcome from R3..R5: 1 = done, 0 = fail; reads = expected read count
   function automatic bit exp_poll(input int n, input int d, output int reads);
      int cnt = 0;
      bit rc = 0;
      for (int p = 0; p < 100; p++) begin
         int  k1;
         bit  tog;
         k1 = 2 * p + 1;
         tog = (k1 < n);
         reads = 2 * (p + 1);
         if (!tog) return 1'b1;
         if (rc) return 1'b0;
         if (k1 >= d) rc = 1;
         else begin
            cnt++;
            if (cnt == MAXP) return 1'b0;
         end
      end
      return 1'b0;
   endfunction

   task automatic wait_result();
      int t = 0;
      while (done_seen == 0 && fail_seen == 0 && t < 3000) begin
         tick();
         t++;
      end
      chk(t < 3000, "R6", "result within timeout", t, 3000);
   endtask

   task automatic run_poll(input int n, input int d, input logic [AW-1:0] a,
                           input bit inject);
      int  er;
      bit  ex;
      model_q = 0; mn = n; md = d; base = tot;
      exp_addr = a; addr_bad = 0; done_seen = 0; fail_seen = 0;
      ex = exp_poll(n, d, er);
      start = 1; query = 0; sector_addr = a;
      tick();
      start = 0;
      chk(busy == 1'b1, "R9", "busy after start", busy, 1);
      if (inject) begin
         repeat (3) tick();
         start = 1; query = 1; sector_addr = ~a;
         tick();
         start = 0;
      end
      wait_result();
      if (ex) chk(done_seen == 1 && fail_seen == 0, inject ? "R7" : "R3", "done outcome",
                  done_seen, 1);
      else    chk(fail_seen == 1 && done_seen == 0, inject ? "R7" : "R4", "fail outcome",
                  fail_seen, 1);
      chk((tot - base) == er, (d < 99) ? "R5" : "R4", "read count", tot - base, er);
      chk(!addr_bad, "R2", "read address", int'(addr_bad), 0);
      chk((ex ? done_cyc : fail_cyc) - last_ack == 2, "R3", "result latency",
          (ex ? done_cyc : fail_cyc) - last_ack, 2);
      chk(busy == 1'b0, "R6", "idle with result", busy, 0);
      tick();
      chk(done == 1'b0 && fail == 1'b0, "R6", "pulse width", int'(done | fail), 0);
   endtask

   task automatic run_query(input bit t6, input bit t2, input logic [AW-1:0] a);
      model_q = 1; q6 = t6; q2 = t2; base = tot;
      exp_addr = a; addr_bad = 0; done_seen = 0; fail_seen = 0;
      start = 1; query = 1; sector_addr = a;
      tick();
      start = 0; query = 0;
      wait_result();
      chk(done_seen == 1 && fail_seen == 0, "R8", "query done", done_seen, 1);
      chk((tot - base) == 2, "R8", "query reads", tot - base, 2);
      chk(st_erasing == t6, "R8", "erasing", st_erasing, int'(t6));
      chk(st_sector_sel == t2, "R8", "sector selected", st_sector_sel, int'(t2));
      chk(st_suspended == (!t6 && t2), "R8", "suspended", st_suspended, int'(!t6 && t2));
      tick();
   endtask

   initial begin
      void'($urandom(32'h5EED_0017));
      repeat (3) tick();
      chk(busy == 0 && done == 0 && fail == 0 && rd_req == 0, "R1", "reset outputs",
          int'({busy, done, fail, rd_req}), 0);
      chk(st_erasing == 0 && st_suspended == 0 && st_sector_sel == 0, "R1",
          "reset status", int'({st_erasing, st_suspended, st_sector_sel}), 0);
      rst_n = 1;
      tick();
      // directed corners
      run_poll(0, 99, 12'h0A5, 0);   // R3 stable from the first pair
      run_poll(2, 99, 12'h123, 0);   // R3 stops after one pair
      run_poll(9, 99, 12'h300, 0);   // R4 stops on the last allowed pair
      run_poll(11, 99, 12'h301, 0);  // R4 limit reached
      run_poll(4, 3, 12'h777, 0);    // R5 race: stops as bit 5 rises
      run_poll(20, 1, 12'h040, 0);   // R5 confirmed toggling
      run_poll(6, 99, 12'h456, 1);   // R7 start while busy
      run_query(1, 1, 12'h010);
      run_query(0, 1, 12'h011);
      run_query(0, 0, 12'h012);
      run_query(1, 0, 12'h013);
      // R8 status held across a poll
      run_query(0, 1, 12'h020);
      run_poll(3, 99, 12'h021, 0);
      chk(st_suspended == 1 && st_sector_sel == 1 && st_erasing == 0, "R8",
          "status held over poll", int'({st_erasing, st_suspended, st_sector_sel}), 3);
      // random mix
      for (int i = 0; i < 40; i++) begin
         int n, d;
         n = int'($urandom_range(0, 14));
         d = ($urandom_range(0, 2) == 0) ? 99 : int'($urandom_range(0, 14));
         run_poll(n, d, AW'($urandom), ($urandom_range(0, 4) == 0));
      end
      for (int i = 0; i < 10; i++)
         run_query(1'($urandom), 1'($urandom), AW'($urandom));
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule